// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter for a peripheral clock domain. A prescale stage counts every clock from zero up to a programmed limit and then returns to zero. Each time it returns to zero, the main count advances by one. The main count is compared against a single programmed compare value. When the two become equal, the block can take up to three actions, each enabled on its own: latch an interrupt flag, restart the main count, or halt counting by clearing the run bit.

Software programs the block through a simple write port. Each write carries a 3-bit address and a data word. The interrupt output is the latched flag itself, and software clears it by writing a one. The main count, the prescale count and the run bit appear on outputs so that a host or a neighbouring block can read them.

A restart takes effect only at the end of the prescale period in which equality was found. The main count therefore shows the compare value for one whole prescale period. The interrupt and the halt both appear on the clock after the main count first takes the compare value.

Top module: `prescaled_match_timer`

## Requirements
- R1: After the synchronous reset `rst`, the main count, prescale count, run bit, interrupt and all programmed values are 0.
- R2: While running, the prescale count steps 0,1,…,P and then returns to 0, where P is the value at address 1. The main count advances by one only on the clock where the prescale count returns to 0, so it advances once every P+1 clocks.
- R3: Address 0, bit 0 is the run bit. While it is 0, neither count changes.
- R4: Address 0, bit 1 is a counter clear. While it is 1, both counts are held at 0 and no compare event is raised.
- R5: The compare value is at address 2. Address 3 holds the actions: bit 0 enables the interrupt, bit 1 enables restart, bit 2 enables halt. With restart enabled, the main count returns to 0 at the end of the prescale period in which it equals the compare value, so it holds that value for P+1 clocks.
- R6: With bit 0 of address 3 set, the interrupt goes to 1 on the clock after the main count first takes the compare value. It stays at 1 until it is cleared.
- R7: With bit 2 of address 3 set, the run bit is cleared on that same clock. Both counts then keep the values they had after that edge. The halt takes priority over a software write to the run bit in the same cycle.
- R8: A compare event is raised only on the first clock of the compare value. A flag that is cleared while the count still holds that value stays at 0.
- R9: With bit 0 of address 3 clear, a compare event leaves the interrupt at 0, but the restart and halt actions still occur as configured.
- R10: Writing data with bit 0 set to address 4 clears the interrupt. If a compare event and that clear fall in the same cycle, the flag ends up set.
- R11: Without a restart, the main count wraps from all-ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address (0 control, 1 prescale limit, 2 compare value, 3 actions, 4 interrupt clear) |
| wr_data | input | CNT_W | Write data |
| irq | output | 1 | Latched compare interrupt |
| count_out | output | CNT_W | Main count |
| prescale_out | output | CNT_W | Prescale count |
| running | output | 1 | Run bit |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a compare event and a software clear of the interrupt. The bench provokes this by writing the clear on the exact clock in which the main count has just taken the compare value, and it expects the flag to read 1 afterwards. The second pair is a halt and continued counting: the halt edge still advances the prescale count once, and the bench compares the frozen counts against values computed from the clock index at which the halt occurs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PLIMIT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ACT    = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQCLR = 3'd4;

  typedef struct packed {
    logic halt;
    logic restart;
    logic intr;
  } act_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              hit_event,
  output logic              run_q,
  output logic              clr_q,
  output logic [CNT_W-1:0]  plimit_q,
  output logic [CNT_W-1:0]  cmp_q,
  output act_t              act_q,
  output logic              irq_q
);
  logic wr_ctrl, wr_plim, wr_cmp, wr_act, wr_iclr;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_plim = wr_en && (wr_addr == A_PLIMIT);
    wr_cmp  = wr_en && (wr_addr == A_CMP);
    wr_act  = wr_en && (wr_addr == A_ACT);
    wr_iclr = wr_en && (wr_addr == A_IRQCLR) && wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      clr_q    <= 1'b0;
      plimit_q <= '0;
      cmp_q    <= '0;
      act_q    <= '0;
    end else begin
      if (hit_event && act_q.halt) run_q <= 1'b0;
      else if (wr_ctrl)            run_q <= wr_data[0];
      if (wr_ctrl) clr_q    <= wr_data[1];
      if (wr_plim) plimit_q <= wr_data;
      if (wr_cmp)  cmp_q    <= wr_data;
      if (wr_act)  act_q    <= act_t'(wr_data[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                           irq_q <= 1'b0;
    else if (hit_event && act_q.intr)  irq_q <= 1'b1;
    else if (wr_iclr)                  irq_q <= 1'b0;
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] pcount,
  output logic             tick
);
  logic at_limit;

  always_comb begin
    at_limit = (pcount >= limit);
    tick     = run && !clr && at_limit;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    pcount <= '0;
    else if (run)      pcount <= at_limit ? '0 : pcount + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             at_cmp,
  input  logic             restart_en,
  output logic [CNT_W-1:0] tcount
);
  always_ff @(posedge clk) begin
    if (rst || clr)                    tcount <= '0;
    else if (tick && restart_en && at_cmp) tcount <= '0;
    else if (tick)                     tcount <= tcount + 1'b1;
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] tcount,
  input  logic [CNT_W-1:0] cmp,
  output logic             at_cmp,
  output logic             hit_event
);
  logic seen_q;

  always_comb begin
    at_cmp    = (tcount == cmp);
    hit_event = at_cmp && !seen_q && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= at_cmp;
  end
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              irq,
  output logic [CNT_W-1:0]  count_out,
  output logic [CNT_W-1:0]  prescale_out,
  output logic              running
);
  logic             run_q, ctrl_clr, tick, at_cmp, hit_event, irq_q;
  logic [CNT_W-1:0] plimit, match_val, pcount, tcount;
  act_t             act;
  logic             mcr_irq, mcr_rst, mcr_stop;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_event(hit_event), .run_q(run_q), .clr_q(ctrl_clr), .plimit_q(plimit),
    .cmp_q(match_val), .act_q(act), .irq_q(irq_q)
  );

  tmr_prescale #(.CNT_W(CNT_W)) u_presc (
    .clk(clk), .rst(rst), .run(run_q), .clr(ctrl_clr), .limit(plimit),
    .pcount(pcount), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(ctrl_clr), .tick(tick), .at_cmp(at_cmp),
    .restart_en(mcr_rst), .tcount(tcount)
  );

  tmr_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst), .clr(ctrl_clr), .tcount(tcount), .cmp(match_val),
    .at_cmp(at_cmp), .hit_event(hit_event)
  );

  always_comb begin
    mcr_irq      = act.intr;
    mcr_rst      = act.restart;
    mcr_stop     = act.halt;
    irq          = irq_q;
    count_out    = tcount;
    prescale_out = pcount;
    running      = run_q;
  end
endmodule

// File: rtl/tmr_check.sv
module tmr_check #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             running,
  input logic             irq,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] prescale_out,
  input logic [CNT_W-1:0] match_val,
  input logic             ctrl_clr,
  input logic             tick,
  input logic             hit_event,
  input logic             mcr_irq,
  input logic             mcr_rst,
  input logic             mcr_stop
);
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ctrl_clr) |=> $stable(count_out)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!running && !ctrl_clr) |=> ($stable(count_out) && $stable(prescale_out))); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctrl_clr |=> (count_out == '0 && prescale_out == '0)); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (mcr_rst && tick && !ctrl_clr && count_out == match_val) |=> (count_out == '0)); // R5
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (hit_event && mcr_irq) |=> irq); // R6
  AST_HALT: assert property (@(posedge clk) disable iff (rst)
    (hit_event && mcr_stop) |=> !running); // R7
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(count_out == match_val)); // R8
endmodule

bind prescaled_match_timer tmr_check #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .running(running), .irq(irq), .count_out(count_out),
  .prescale_out(prescale_out), .match_val(match_val), .ctrl_clr(ctrl_clr),
  .tick(tick), .hit_event(hit_event), .mcr_irq(mcr_irq), .mcr_rst(mcr_rst),
  .mcr_stop(mcr_stop)
);

// File: tb/prescaled_match_timer_test.sv
module prescaled_match_timer_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         irq, running;
  logic [W-1:0] count_out, prescale_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prescaled_match_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .count_out(count_out), .prescale_out(prescale_out), .running(running)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after the write edge
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = addr[2:0];
    wr_data = data[W-1:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic setup(input int pr, input int mr, input int act);
    wr(0, 2);
    wr(1, pr);
    wr(2, mr);
    wr(3, act);
    wr(4, 1);
    wr(0, 1);
  endtask

  task automatic run_case(input int pr, input int mr, input int act, input int n);
    int p, kk, km, kf, etc, epc, eirq, erun;
    p  = pr + 1;
    km = mr * p;
    setup(pr, mr, act);
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk);
      kf = ((act & 4) != 0 && k > km + 1) ? km + 1 : k;
      kk = kf / p;
      epc = kf % p;
      etc = ((act & 2) != 0) ? kk % (mr + 1) : kk % 256;
      eirq = ((act & 1) != 0 && k >= km + 1) ? 1 : 0;
      erun = ((act & 4) != 0 && k >= km + 1) ? 0 : 1;
      chk("R2 prescale count", int'(prescale_out), epc);
      chk(((act & 2) != 0) ? "R5 main count restart" : "R2 main count", int'(count_out), etc);
      chk(((act & 1) != 0) ? "R6 interrupt" : "R9 interrupt masked", int'(irq), eirq);
      chk("R7 run bit", int'(running), erun);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 count", int'(count_out), 0);
    chk("R1 prescale", int'(prescale_out), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 running", int'(running), 0);

    // R2 R5 R6 R7 R9: sweep over limits, compare values and action sets
    for (int pr = 0; pr < 4; pr++)
      for (int mr = 1; mr < 5; mr++) begin
        run_case(pr, mr, 3, 2 * (mr + 1) * (pr + 1) + 3);
        run_case(pr, mr, 5, 2 * (mr + 1) * (pr + 1) + 3);
        run_case(pr, mr, 2, 2 * (mr + 1) * (pr + 1) + 3);
        run_case(pr, mr, 6, 2 * (mr + 1) * (pr + 1) + 3);
        run_case(pr, mr, 1, 2 * (mr + 1) * (pr + 1) + 3);
      end

    // R11: wrap from all-ones with no actions
    run_case(0, 1, 0, 260);

    // R3: run bit cleared mid-count
    setup(1, 100, 0);
    repeat (5) @(negedge clk);
    chk("R3 pre count", int'(count_out), 2);
    wr(0, 0);
    chk("R3 last step count", int'(count_out), 3);
    chk("R3 last step prescale", int'(prescale_out), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R3 held count", int'(count_out), 3);
      chk("R3 held prescale", int'(prescale_out), 0);
    end

    // R4: counter clear holds zero even with run bit set
    wr(0, 3);
    chk("R4 clear edge count", int'(count_out), 3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 cleared count", int'(count_out), 0);
      chk("R4 cleared prescale", int'(prescale_out), 0);
    end
    wr(0, 1);
    chk("R4 release count", int'(count_out), 0);
    repeat (3) @(negedge clk);
    chk("R4 resumed prescale", int'(prescale_out), 1);
    chk("R4 resumed count", int'(count_out), 1);

    // R8: clear during the hold of the compare value stays clear
    setup(3, 2, 1);
    repeat (9) @(negedge clk);
    chk("R8 irq raised", int'(irq), 1);
    chk("R8 count at compare", int'(count_out), 2);
    wr(4, 1);
    chk("R8 cleared in hold", int'(irq), 0);
    chk("R8 still holding", int'(count_out), 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no re-raise", int'(irq), 0);
    end

    // R10: event and clear in the same cycle, set wins
    setup(0, 3, 1);
    repeat (3) @(negedge clk);
    chk("R10 count at compare", int'(count_out), 3);
    chk("R10 irq before", int'(irq), 0);
    wr(4, 1);
    chk("R10 set wins", int'(irq), 1);
    wr(4, 0);
    chk("R10 bit0 zero ignored", int'(irq), 1);
    wr(4, 1);
    chk("R10 cleared", int'(irq), 0);

    // R7: halt wins over a run-bit write in the same cycle
    setup(0, 2, 4);
    repeat (2) @(negedge clk);
    wr(0, 1);
    chk("R7 halt wins", int'(running), 0);
    chk("R7 frozen count", int'(count_out), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule